// File: doc/BRIEF.md
# Multi-function GPIO pin controller

This block governs one shared pin that can serve as a serial chip-select input, as a jack-detect input, or as a general-purpose output. A three-bit source field decides what the pin drives: a temperature-good flag, an auto-mute flag, a PLL lock flag, a divided PLL clock, or a fixed level. Selecting the input code, or the reserved code, leaves the pad undriven.

The chosen level can be inverted. It can then be driven push-pull, or in open-drain fashion where the pad is only pulled low and is released for a high. Pull-up and pull-down requests are produced for the pad cell. A strap input selects 3-wire serial control. When the strap is set, the pin is always the chip-select input, whatever the source field holds. The two-bit PLL divide field also sets the high-pass filter cut-off, so the block drives that field onto both consumers.

The configuration lives in two small registers behind a one-cycle write port. All pad controls are registered. The chip-select path is combinational, so the serial port sees the pin without delay.

Top module: `gpio_mux_pin`

## Requirements
- R1: After reset the source field, invert, open-drain, pull and divide settings are all 0. In this state `pad_oe`, `pad_pu`, `pad_pd`, `jack_det`, `clk_div_sel` and `hpf_cut` read 0 and `csb_n` reads 1 while the strap is low.
- R2: A write with `cfg_addr`=0 loads the pin control from `cfg_wdata`: bits [2:0] source, bit 3 invert, bit 4 open-drain, bit 5 pull-down, bit 6 pull-up. A write with `cfg_addr`=1 loads the divide field from bits [1:0]. Pad controls follow on the second rising edge after the write is presented.
- R3: With `mode_3wire` high, `pad_oe` is 0 for every source code, `jack_det` is 0, and `csb_n` equals `pad_in` with no clock delay. With the strap low, `csb_n` is 1.
- R4: Source code 000 (input) and code 001 (reserved) both hold `pad_oe` at 0 and `pad_out` at 0.
- R5: In push-pull mode the driven level is: code 010 the temperature-good flag, 011 the auto-mute flag, 100 the divided PLL clock, 101 the lock flag, 110 logic 0, 111 logic 1. A change of a status input reaches `pad_out` on the next rising edge.
- R6: When invert is set, the selected level is complemented before it reaches the pad.
- R7: In open-drain mode `pad_out` is 0 and `pad_oe` is the complement of the (possibly inverted) level.
- R8: `pad_pd` follows the pull-down bit. `pad_pu` follows the pull-up bit only while pull-down is clear, so the two are never 1 together.
- R9: Divide codes 00, 01, 10 and 11 give a PLL clock output period of 1, 2, 3 and 4 `pll_clk` periods. The divider restarts when the code changes.
- R10: `clk_div_sel` and `hpf_cut` both carry the stored divide field one rising edge after its write.
- R11: With source 000 and the strap low, `jack_det` shows `pad_in` after a two-stage synchroniser, on the second rising edge after `pad_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 pin control, 1 divide field |
| cfg_wdata | input | 7 | Register write data |
| mode_3wire | input | 1 | Strap: 1 selects 3-wire serial control |
| temp_ok | input | 1 | Temperature-good status flag |
| amute_active | input | 1 | Auto-mute active status flag |
| pll_lock | input | 1 | PLL lock status flag |
| pll_clk | input | 1 | PLL clock, sampled in the `clk` domain |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad output enable |
| pad_pu | output | 1 | Pull-up request |
| pad_pd | output | 1 | Pull-down request |
| csb_n | output | 1 | Chip-select to the serial port, active low |
| jack_det | output | 1 | Synchronised jack-detect level |
| clk_div_sel | output | 2 | Divide field for the PLL clock output |
| hpf_cut | output | 2 | Same field, used as the high-pass cut-off |

## Verification
A configuration write lands in its register on the first rising edge. Pad drive, enable and pulls follow one edge later, so the bench checks them at the falling edge after the second rising edge. Status flag changes take one edge, and the jack-detect level takes two edges through its synchroniser. The exported divide field and the combinational chip-select are checked after one edge and after a short settling delay respectively. Divider ratios are measured as the count of falling-edge samples between consecutive rising edges of `pad_out`, which removes the fixed pipeline delay from the result.

// File: rtl/gpio_pin_pkg.sv
`timescale 1ns/1ps
package gpio_pin_pkg;

    typedef enum logic [2:0] {
        SEL_INPUT  = 3'b000,
        SEL_RSVD   = 3'b001,
        SEL_TEMP   = 3'b010,
        SEL_AMUTE  = 3'b011,
        SEL_PLLCLK = 3'b100,
        SEL_LOCK   = 3'b101,
        SEL_ZERO   = 3'b110,
        SEL_ONE    = 3'b111
    } pin_sel_e;

    typedef struct packed {
        logic     pull_up;
        logic     pull_dn;
        logic     od_en;
        logic     invert;
        pin_sel_e sel;
    } pin_ctl_t;

    localparam int CTL_W = $bits(pin_ctl_t);
    localparam int DIV_W = 2;

endpackage

// File: rtl/gpio_cfg_regs.sv
`timescale 1ns/1ps
module gpio_cfg_regs
    import gpio_pin_pkg::*;
#(
    parameter int DATA_W = CTL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output pin_ctl_t            ctl_o,
    output logic [DIV_W-1:0]    div_o
);
    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_DIV = 1'b1;

    typedef struct packed {
        pin_ctl_t          ctl;
        logic [DIV_W-1:0]  div;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == ADDR_CTL) begin
                st_d.ctl = pin_ctl_t'(wr_data[CTL_W-1:0]);
            end
            if (wr_addr == ADDR_DIV) begin
                st_d.div = wr_data[DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o = st_q.ctl;
    assign div_o = st_q.div;

    // R2: a divide write leaves the pin control untouched
    a_r2_div_write_keeps_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DIV) |=> $stable(ctl_o));

endmodule

// File: rtl/gpio_clk_div.sv
`timescale 1ns/1ps
module gpio_clk_div
    import gpio_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_clk,
    input  logic [DIV_W-1:0]  div_sel,
    output logic              div_clk
);
    localparam int RATIO_W = DIV_W + 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [DIV_W-1:0]       cnt;
        logic [DIV_W-1:0]       div_prev;
    } div_st_t;

    div_st_t st_d, st_q;

    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half;
    logic               pll_s;
    logic               rise;

    assign ratio = {1'b0, div_sel} + RATIO_W'(1);
    assign half  = ratio >> 1;
    assign pll_s = st_q.sync[SYNC_STAGES-1];
    assign rise  = pll_s && !st_q.prev;

    always_comb begin
        st_d          = st_q;
        st_d.sync     = {st_q.sync[SYNC_STAGES-2:0], pll_clk};
        st_d.prev     = pll_s;
        st_d.div_prev = div_sel;
        if (div_sel != st_q.div_prev) begin
            st_d.cnt = '0;
        end else if (rise) begin
            if ({1'b0, st_q.cnt} == ratio - RATIO_W'(1)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (div_sel == '0) begin
            div_clk = pll_s;
        end else begin
            div_clk = ({1'b0, st_q.cnt} < half);
        end
    end

    // R9: the phase counter stays below the ratio it was counting for
    a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.cnt} < ({1'b0, st_q.div_prev} + RATIO_W'(1))));

endmodule

// File: rtl/gpio_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_pad_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_ctl_t ctl,
    input  logic     mode_3wire,
    input  logic     temp_ok,
    input  logic     amute_active,
    input  logic     pll_lock,
    input  logic     div_clk,
    input  logic     pad_in,
    output logic     pad_out,
    output logic     pad_oe,
    output logic     pad_pu,
    output logic     pad_pd,
    output logic     jack_det
);
    typedef struct packed {
        logic                   out;
        logic                   oe;
        logic                   pu;
        logic                   pd;
        logic [SYNC_STAGES-1:0] sync;
    } pad_st_t;

    pad_st_t st_d, st_q;

    logic src;
    logic level;
    logic drive_en;

    always_comb begin
        case (ctl.sel)
            SEL_TEMP:   src = temp_ok;
            SEL_AMUTE:  src = amute_active;
            SEL_PLLCLK: src = div_clk;
            SEL_LOCK:   src = pll_lock;
            SEL_ONE:    src = 1'b1;
            default:    src = 1'b0;
        endcase
    end

    assign level    = src ^ ctl.invert;
    assign drive_en = !mode_3wire && (ctl.sel != SEL_INPUT) && (ctl.sel != SEL_RSVD);

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pad_in};
        st_d.pd   = ctl.pull_dn;
        st_d.pu   = ctl.pull_up && !ctl.pull_dn;
        if (!drive_en) begin
            st_d.out = 1'b0;
            st_d.oe  = 1'b0;
        end else if (ctl.od_en) begin
            st_d.out = 1'b0;
            st_d.oe  = !level;
        end else begin
            st_d.out = level;
            st_d.oe  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pad_out  = st_q.out;
    assign pad_oe   = st_q.oe;
    assign pad_pu   = st_q.pu;
    assign pad_pd   = st_q.pd;
    assign jack_det = st_q.sync[SYNC_STAGES-1] && !mode_3wire && (ctl.sel == SEL_INPUT);

    // R8: never both pulls at once
    a_r8_one_pull: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_pu && pad_pd));

    // R7: open-drain never drives a high
    a_r7_od_low: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.od_en |=> !pad_out);

    // R4: reserved and input codes leave the pad released
    a_r4_rsvd_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.sel == SEL_RSVD || ctl.sel == SEL_INPUT) |=> !pad_oe);

endmodule

// File: rtl/gpio_mux_pin.sv
`timescale 1ns/1ps
module gpio_mux_pin
    import gpio_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              mode_3wire,
    input  logic              temp_ok,
    input  logic              amute_active,
    input  logic              pll_lock,
    input  logic              pll_clk,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              pad_pu,
    output logic              pad_pd,
    output logic              csb_n,
    output logic              jack_det,
    output logic [DIV_W-1:0]  clk_div_sel,
    output logic [DIV_W-1:0]  hpf_cut
);
    pin_ctl_t          ctl;
    logic [DIV_W-1:0]  div_field;
    logic              div_clk;

    gpio_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .ctl_o   (ctl),
        .div_o   (div_field)
    );

    gpio_clk_div #(.SYNC_STAGES(SYNC_STAGES)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .pll_clk (pll_clk),
        .div_sel (div_field),
        .div_clk (div_clk)
    );

    gpio_pad_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_pad (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl          (ctl),
        .mode_3wire   (mode_3wire),
        .temp_ok      (temp_ok),
        .amute_active (amute_active),
        .pll_lock     (pll_lock),
        .div_clk      (div_clk),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pad_pu       (pad_pu),
        .pad_pd       (pad_pd),
        .jack_det     (jack_det)
    );

    assign csb_n       = mode_3wire ? pad_in : 1'b1;
    assign clk_div_sel = div_field;
    assign hpf_cut     = div_field;

    // R3: strap forces the pin into input use
    a_r3_strap_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        mode_3wire |=> !pad_oe);

    a_r3_strap_no_jack: assert property (@(posedge clk) disable iff (!rst_n)
        mode_3wire |-> !jack_det);

endmodule

// File: tb/gpio_mux_pin_bench.sv
`timescale 1ns/1ps
module gpio_mux_pin_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       mode_3wire = 1'b0;
    logic       temp_ok = 1'b0;
    logic       amute_active = 1'b0;
    logic       pll_lock = 1'b0;
    logic       pll_clk = 1'b0;
    logic       pad_in = 1'b0;
    logic       pad_out, pad_oe, pad_pu, pad_pd, csb_n, jack_det;
    logic [1:0] clk_div_sel, hpf_cut;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_mux_pin u_gpio_mux_pin (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mode_3wire(mode_3wire), .temp_ok(temp_ok),
        .amute_active(amute_active), .pll_lock(pll_lock), .pll_clk(pll_clk),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .csb_n(csb_n), .jack_det(jack_det),
        .clk_div_sel(clk_div_sel), .hpf_cut(hpf_cut)
    );

    // PLL clock: period of six block clocks
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            pll_clk = ~pll_clk;
        end
    end

    // fields: sel[9:7] inv[6] od[5] temp[4] amute[3] lock[2] exp_out[1] exp_oe[0]
    localparam logic [9:0] VEC [14] = '{
        10'b010_0_0_1_0_0_1_1,
        10'b010_0_0_0_0_0_0_1,
        10'b011_0_0_0_1_0_1_1,
        10'b101_0_0_0_0_1_1_1,
        10'b101_1_0_0_0_1_0_1,
        10'b110_0_0_0_0_0_0_1,
        10'b111_0_0_0_0_0_1_1,
        10'b110_1_0_0_0_0_1_1,
        10'b111_0_1_0_0_0_0_0,
        10'b110_0_1_0_0_0_0_1,
        10'b010_1_1_0_0_0_0_0,
        10'b001_0_0_1_1_1_0_0,
        10'b000_0_0_1_1_1_0_0,
        10'b011_1_0_0_0_0_1_1
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [6:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = addr;
        cfg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic wr_ctl(input logic pu, input logic pd, input logic od,
                          input logic inv, input logic [2:0] sel);
        wr(1'b0, {pu, pd, od, inv, sel});
    endtask

    task automatic measure(output int period);
        logic prev;
        prev = pad_out;
        forever begin
            @(negedge clk);
            if (pad_out && !prev) break;
            prev = pad_out;
        end
        period = 0;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            period++;
            if (pad_out && !prev) break;
            prev = pad_out;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_pu", pad_pu, 0);
        chk("R1 pad_pd", pad_pd, 0);
        chk("R1 jack_det", jack_det, 0);
        chk("R1 csb_n", csb_n, 1);
        chk("R1 clk_div_sel", clk_div_sel, 0);
        chk("R1 hpf_cut", hpf_cut, 0);

        // Table: R2 register layout, R4 hi-z codes, R5 sources, R6 invert, R7 open-drain
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            temp_ok      = VEC[i][4];
            amute_active = VEC[i][3];
            pll_lock     = VEC[i][2];
            wr_ctl(1'b0, 1'b0, VEC[i][5], VEC[i][6], VEC[i][9:7]);
            @(negedge clk);
            chk($sformatf("R2/R4/R5/R6/R7 vec %0d pad_out", i), pad_out, int'(VEC[i][1]));
            chk($sformatf("R2/R4/R5/R6/R7 vec %0d pad_oe", i), pad_oe, int'(VEC[i][0]));
        end

        // R5 status change reaches the pad one edge later
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b101);
        @(negedge clk);
        pll_lock = 1'b0;
        @(negedge clk);
        chk("R5 lock fall one edge", pad_out, 0);
        pll_lock = 1'b1;
        @(negedge clk);
        chk("R5 lock rise one edge", pad_out, 1);

        // R8 pull priority
        wr_ctl(1'b1, 1'b0, 1'b0, 1'b0, 3'b000);
        @(negedge clk);
        chk("R8 pu only: pu", pad_pu, 1);
        chk("R8 pu only: pd", pad_pd, 0);
        wr_ctl(1'b1, 1'b1, 1'b0, 1'b0, 3'b000);
        @(negedge clk);
        chk("R8 both: pu", pad_pu, 0);
        chk("R8 both: pd", pad_pd, 1);
        wr_ctl(1'b0, 1'b1, 1'b0, 1'b0, 3'b000);
        @(negedge clk);
        chk("R8 pd only: pd", pad_pd, 1);

        // R11 jack detect through synchroniser
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b000);
        @(negedge clk);
        pad_in = 1'b1;
        @(negedge clk);
        chk("R11 jack after one edge", jack_det, 0);
        @(negedge clk);
        chk("R11 jack after two edges", jack_det, 1);
        chk("R3 csb idle with strap low", csb_n, 1);
        chk("R4 input code oe", pad_oe, 0);

        // R3 strap overrides a driving code
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b111);
        @(negedge clk);
        mode_3wire = 1'b1;
        pad_in = 1'b0;
        #1;
        chk("R3 csb follows pad low", csb_n, 0);
        pad_in = 1'b1;
        #1;
        chk("R3 csb follows pad high", csb_n, 1);
        @(negedge clk);
        chk("R3 no drive under strap", pad_oe, 0);
        chk("R3 no jack under strap", jack_det, 0);
        mode_3wire = 1'b0;
        @(negedge clk);
        chk("R3 drive returns after strap", pad_oe, 1);

        // R10 shared divide field
        wr(1'b1, 7'b0000010);
        chk("R10 clk_div_sel", clk_div_sel, 2);
        chk("R10 hpf_cut", hpf_cut, 2);

        // R9 divide ratios, changed without reset
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b0, 3'b100);
        for (int n = 0; n < 4; n++) begin
            wr(1'b1, 7'(n));
            measure(p);
            measure(p);
            chk($sformatf("R9 period code %0d", n), p, 6 * (n + 1));
        end
        wr(1'b1, 7'd2);
        measure(p);
        measure(p);
        chk("R9 period after 4->3 change", p, 18);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule